// File: doc/BRIEF.md
# GPIO Bank Pin Control Registers

This block is the register side of a 32-pin general-purpose I/O bank. Software reaches it through a small memory-mapped port: a request carries a write flag, a word address and write data, and a read returns its data one cycle later. Inside, six bitmaps set how each pin behaves: output data, direction, two function-select maps, pull disable and sleep behaviour. Bit n of every bitmap belongs to pin n. From these bitmaps the block produces registered pad-ring controls for each pin: output enable, output value, pull enable, pull direction and a 2-bit function code.

Output data and direction are never written whole. Each has a set address and a clear address, and only the bits written as 1 change. Any number of agents can therefore change different pins without a read-modify-write. An enabled pull takes its direction from the pin's data-out bit, so one bit serves both as the driven value and as the pull polarity. Reads of the data address return the pad input after a synchronizer.

When a pin selects an alternate function, its output enable and output value come from the peripheral side (`alt_oe`, `alt_out`). While `sleep_i` is high, a pin whose sleep bit is 0 is forced to be an input.

Top module: `gpio_bank`

## Requirements
- R1: After reset all six bitmaps read 0, pad_oe, pad_out, pad_pull_up and pad_func are 0, and pad_pull_en is all ones.
- R2: A write to address 1 sets each data-out bit written as 1 and leaves every other bit unchanged. Reads of address 1 or 2 return the data-out register.
- R3: A write to address 2 clears each data-out bit written as 1 and leaves every other bit unchanged.
- R4: A write to address 4 makes the pins written as 1 outputs, and a write to address 5 makes them inputs. Reads of address 3, 4 or 5 return the direction register (1 = output). Writes to address 3 have no effect.
- R5: Address 6 (map A) and address 7 (map B) are read/write. pad_func[2n+1:2n] equals {B[n],A[n]}: 00 GPIO, 01 alternate A, 10 alternate B, 11 alternate C.
- R6: A pin in GPIO function drives pad_oe from its direction bit and pad_out from its data-out bit. A pin in any alternate function takes both from alt_oe and alt_out.
- R7: Address 8 holds the pull-disable map (1 = no pull). pad_pull_en[n] is 1 only when the pull-disable bit is 0 and pad_oe[n] is 0. pad_pull_up[n] equals data-out bit n (1 = up, 0 = down).
- R8: Address 9 holds the sleep map and is read/write. While sleep_i is 1, each pin whose sleep bit is 0 has pad_oe forced to 0, and each pin whose sleep bit is 1 keeps its configuration.
- R9: A read of address 0 returns pad_in through a two-flop synchronizer. A read whose request edge comes two clocks after pad_in changes still returns the old value, and a read one clock after that returns the new value. Writes to address 0 have no effect.
- R10: req_ready is always 1. rsp_valid is 1 exactly in the cycle after each accepted read. Reads of addresses 10 to 15 return 0, and writes to them change nothing.
- R11: Pad outputs are registered: they take a new value one clock after the register write that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| alt_oe | input | 32 | Output enable from the selected alternate function |
| alt_out | input | 32 | Output value from the selected alternate function |
| sleep_i | input | 1 | Bank is in sleep |
| pad_oe | output | 32 | Pad output enable |
| pad_out | output | 32 | Pad output value |
| pad_pull_en | output | 32 | Pad pull enable |
| pad_pull_up | output | 32 | Pull direction, 1 = up |
| pad_func | output | 64 | Function code, two bits per pin |

## Verification
The assertions check on every cycle the rules that can be stated cycle by cycle:
- the set and clear updates of data-out;
- that a pull is never enabled on a driven pin;
- that the pull direction follows data-out one cycle later;
- the function code mapping;
- the sleep override;
- the read response timing, and zeros on undefined addresses.

Only the bench scenarios can show the rest. These are the reset contents, the registered one-cycle lag of the pad controls, the hand-over of drive to the alternate-function inputs, the exact synchronizer latency on pad reads, and that writes to read-only or unmapped addresses leave the state unchanged.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Word addresses of the register port
  localparam int unsigned A_PADIN   = 0;
  localparam int unsigned A_DSET    = 1;
  localparam int unsigned A_DCLR    = 2;
  localparam int unsigned A_DIR     = 3;
  localparam int unsigned A_DIRSET  = 4;
  localparam int unsigned A_DIRCLR  = 5;
  localparam int unsigned A_FSELA   = 6;
  localparam int unsigned A_FSELB   = 7;
  localparam int unsigned A_PULLDIS = 8;
  localparam int unsigned A_SLEEP   = 9;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_ALTA = 2'b01,
    FN_ALTB = 2'b10,
    FN_ALTC = 2'b11
  } pin_fn_e;

  typedef struct packed {
    logic dset;
    logic dclr;
    logic dirset;
    logic dirclr;
    logic fsela;
    logic fselb;
    logic pulldis;
    logic sleep;
  } wr_dec_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPINS-1:0]  req_wdata,
  input  logic [NPINS-1:0]  pad_sync,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  fa_q,
  output logic [NPINS-1:0]  fb_q,
  output logic [NPINS-1:0]  pdis_q,
  output logic [NPINS-1:0]  slp_q,
  output logic              rsp_valid,
  output logic [NPINS-1:0]  rsp_rdata
);

  wr_dec_t          wdec;
  logic             wr_en;
  logic             rd_en;
  logic [NPINS-1:0] rd_mux;

  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  always_comb begin
    wdec         = '0;
    wdec.dset    = wr_en && (req_addr == ADDR_W'(A_DSET));
    wdec.dclr    = wr_en && (req_addr == ADDR_W'(A_DCLR));
    wdec.dirset  = wr_en && (req_addr == ADDR_W'(A_DIRSET));
    wdec.dirclr  = wr_en && (req_addr == ADDR_W'(A_DIRCLR));
    wdec.fsela   = wr_en && (req_addr == ADDR_W'(A_FSELA));
    wdec.fselb   = wr_en && (req_addr == ADDR_W'(A_FSELB));
    wdec.pulldis = wr_en && (req_addr == ADDR_W'(A_PULLDIS));
    wdec.sleep   = wr_en && (req_addr == ADDR_W'(A_SLEEP));
  end

  // Set/clear registers: only bits written as one move
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wdec.dset)   dout_q <= dout_q | req_wdata;
      if (wdec.dclr)   dout_q <= dout_q & ~req_wdata;
      if (wdec.dirset) dir_q  <= dir_q | req_wdata;
      if (wdec.dirclr) dir_q  <= dir_q & ~req_wdata;
    end
  end

  // Plain read/write bitmaps
  always_ff @(posedge clk) begin
    if (rst) begin
      fa_q   <= '0;
      fb_q   <= '0;
      pdis_q <= '0;
      slp_q  <= '0;
    end else begin
      if (wdec.fsela)   fa_q   <= req_wdata;
      if (wdec.fselb)   fb_q   <= req_wdata;
      if (wdec.pulldis) pdis_q <= req_wdata;
      if (wdec.sleep)   slp_q  <= req_wdata;
    end
  end

  always_comb begin
    case (req_addr)
      ADDR_W'(A_PADIN):   rd_mux = pad_sync;
      ADDR_W'(A_DSET),
      ADDR_W'(A_DCLR):    rd_mux = dout_q;
      ADDR_W'(A_DIR),
      ADDR_W'(A_DIRSET),
      ADDR_W'(A_DIRCLR):  rd_mux = dir_q;
      ADDR_W'(A_FSELA):   rd_mux = fa_q;
      ADDR_W'(A_FSELB):   rd_mux = fb_q;
      ADDR_W'(A_PULLDIS): rd_mux = pdis_q;
      ADDR_W'(A_SLEEP):   rd_mux = slp_q;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/gpio_bank_padctl.sv
module gpio_bank_padctl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPINS-1:0]     dout_q,
  input  logic [NPINS-1:0]     dir_q,
  input  logic [NPINS-1:0]     fa_q,
  input  logic [NPINS-1:0]     fb_q,
  input  logic [NPINS-1:0]     pdis_q,
  input  logic [NPINS-1:0]     slp_q,
  input  logic                 sleep_i,
  input  logic [NPINS-1:0]     alt_oe,
  input  logic [NPINS-1:0]     alt_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_pull_en,
  output logic [NPINS-1:0]     pad_pull_up,
  output logic [2*NPINS-1:0]   pad_func
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_fn_e fn;
    logic    oe_nxt;
    logic    out_nxt;

    always_comb begin
      fn = pin_fn_e'({fb_q[p], fa_q[p]});
      if (fn == FN_GPIO) begin
        oe_nxt  = dir_q[p];
        out_nxt = dout_q[p];
      end else begin
        oe_nxt  = alt_oe[p];
        out_nxt = alt_out[p];
      end
      // Sleep turns pins without the keep bit into inputs
      if (sleep_i && !slp_q[p]) oe_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[p]        <= 1'b0;
        pad_out[p]       <= 1'b0;
        pad_pull_en[p]   <= 1'b1;
        pad_pull_up[p]   <= 1'b0;
        pad_func[2*p+:2] <= FN_GPIO;
      end else begin
        pad_oe[p]        <= oe_nxt;
        pad_out[p]       <= out_nxt;
        pad_pull_en[p]   <= !pdis_q[p] && !oe_nxt;
        pad_pull_up[p]   <= dout_q[p];
        pad_func[2*p+:2] <= fn;
      end
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [NPINS-1:0]     req_wdata,
  output logic                 rsp_valid,
  output logic [NPINS-1:0]     rsp_rdata,
  input  logic [NPINS-1:0]     pad_in,
  input  logic [NPINS-1:0]     alt_oe,
  input  logic [NPINS-1:0]     alt_out,
  input  logic                 sleep_i,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_pull_en,
  output logic [NPINS-1:0]     pad_pull_up,
  output logic [2*NPINS-1:0]   pad_func
);

  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] dout_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] fa_q;
  logic [NPINS-1:0] fb_q;
  logic [NPINS-1:0] pdis_q;
  logic [NPINS-1:0] slp_q;

  assign req_ready = 1'b1;

  gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pad_in),
    .d_out (pad_sync)
  );

  gpio_bank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .pad_sync  (pad_sync),
    .dout_q    (dout_q),
    .dir_q     (dir_q),
    .fa_q      (fa_q),
    .fb_q      (fb_q),
    .pdis_q    (pdis_q),
    .slp_q     (slp_q),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  gpio_bank_padctl #(.NPINS(NPINS)) u_padctl (
    .clk         (clk),
    .rst         (rst),
    .dout_q      (dout_q),
    .dir_q       (dir_q),
    .fa_q        (fa_q),
    .fb_q        (fb_q),
    .pdis_q      (pdis_q),
    .slp_q       (slp_q),
    .sleep_i     (sleep_i),
    .alt_oe      (alt_oe),
    .alt_out     (alt_out),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up),
    .pad_func    (pad_func)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [NPINS-1:0]   req_wdata,
  input logic               rsp_valid,
  input logic [NPINS-1:0]   rsp_rdata,
  input logic [NPINS-1:0]   pad_oe,
  input logic [NPINS-1:0]   pad_pull_en,
  input logic [NPINS-1:0]   pad_pull_up,
  input logic [2*NPINS-1:0] pad_func,
  input logic               sleep_i,
  input logic [NPINS-1:0]   dout_q,
  input logic [NPINS-1:0]   fa_q,
  input logic [NPINS-1:0]   fb_q,
  input logic [NPINS-1:0]   slp_q
);

  // R2
  dset_update_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == ADDR_W'(A_DSET))
    |=> dout_q == ($past(dout_q) | $past(req_wdata)));

  // R3
  dclr_update_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == ADDR_W'(A_DCLR))
    |=> dout_q == ($past(dout_q) & ~$past(req_wdata)));

  // R7
  pull_on_driven_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_en & pad_oe) == '0);

  // R7
  pull_dir_chk: assert property (@(posedge clk) disable iff (rst)
    pad_pull_up == $past(dout_q));

  // R8
  sleep_input_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> (pad_oe & ~$past(slp_q)) == '0);

  // R10
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R10
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr > ADDR_W'(A_SLEEP)) |=> rsp_rdata == '0);

  for (genvar p = 0; p < NPINS; p++) begin : g_fn
    // R5
    func_code_chk: assert property (@(posedge clk) disable iff (rst)
      pad_func[2*p+:2] == $past({fb_q[p], fa_q[p]}));
  end

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .pad_oe      (pad_oe),
  .pad_pull_en (pad_pull_en),
  .pad_pull_up (pad_pull_up),
  .pad_func    (pad_func),
  .sleep_i     (sleep_i),
  .dout_q      (dout_q),
  .fa_q        (fa_q),
  .fb_q        (fb_q),
  .slp_q       (slp_q)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;

  localparam int NP = 32;
  localparam int AW = 4;
  localparam int NV = 22;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [NP-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [NP-1:0] rsp_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] alt_oe = '0;
  logic [NP-1:0] alt_out = '0;
  logic          sleep_i = 1'b0;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_pull_en;
  logic [NP-1:0] pad_pull_up;
  logic [2*NP-1:0] pad_func;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pad_in(pad_in),
    .alt_oe(alt_oe), .alt_out(alt_out), .sleep_i(sleep_i),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .pad_func(pad_func)
  );

  // {req tag, write, addr, data, expected read}
  localparam logic [72:0] VEC [NV] = '{
    {4'd2,  1'b1, 4'd1,  32'h0000_00FF, 32'h0},           // R2 set
    {4'd2,  1'b0, 4'd1,  32'h0,         32'h0000_00FF},   // R2
    {4'd3,  1'b1, 4'd2,  32'h0000_000F, 32'h0},           // R3 clear
    {4'd3,  1'b0, 4'd2,  32'h0,         32'h0000_00F0},   // R3
    {4'd2,  1'b1, 4'd1,  32'hA500_0000, 32'h0},           // R2
    {4'd2,  1'b0, 4'd1,  32'h0,         32'hA500_00F0},   // R2
    {4'd4,  1'b1, 4'd4,  32'h0000_FFFF, 32'h0},           // R4 dir set
    {4'd4,  1'b1, 4'd5,  32'h0000_00FF, 32'h0},           // R4 dir clear
    {4'd4,  1'b0, 4'd3,  32'h0,         32'h0000_FF00},   // R4
    {4'd4,  1'b1, 4'd3,  32'hFFFF_FFFF, 32'h0},           // R4 ignored write
    {4'd4,  1'b0, 4'd4,  32'h0,         32'h0000_FF00},   // R4
    {4'd5,  1'b1, 4'd6,  32'h1234_5678, 32'h0},           // R5
    {4'd5,  1'b0, 4'd6,  32'h0,         32'h1234_5678},   // R5
    {4'd5,  1'b1, 4'd7,  32'h0F0F_0000, 32'h0},           // R5
    {4'd5,  1'b0, 4'd7,  32'h0,         32'h0F0F_0000},   // R5
    {4'd7,  1'b1, 4'd8,  32'hFFFF_0000, 32'h0},           // R7
    {4'd7,  1'b0, 4'd8,  32'h0,         32'hFFFF_0000},   // R7
    {4'd8,  1'b1, 4'd9,  32'h8000_0001, 32'h0},           // R8
    {4'd8,  1'b0, 4'd9,  32'h0,         32'h8000_0001},   // R8
    {4'd10, 1'b1, 4'd12, 32'hDEAD_BEEF, 32'h0},           // R10 unmapped write
    {4'd10, 1'b0, 4'd12, 32'h0,         32'h0},           // R10
    {4'd10, 1'b0, 4'd15, 32'h0,         32'h0}            // R10
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] r;
    do_reset();

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68]) begin
        wr(VEC[i][67:64], VEC[i][63:32]);
      end else begin
        rd(VEC[i][67:64], r);
        check($sformatf("R%0d vec%0d", VEC[i][72:69], i), 64'(r), 64'(VEC[i][31:0]));
      end
    end

    // R1 reset state
    do_reset();
    @(negedge clk);
    check("R1 pad_oe", 64'(pad_oe), 64'h0);
    check("R1 pad_out", 64'(pad_out), 64'h0);
    check("R1 pad_pull_en", 64'(pad_pull_en), 64'hFFFF_FFFF);
    check("R1 pad_pull_up", 64'(pad_pull_up), 64'h0);
    check("R1 pad_func", pad_func, 64'h0);
    check("R10 req_ready", 64'(req_ready), 64'h1);
    for (int a = 1; a <= 9; a++) begin
      rd(AW'(a), r);
      check($sformatf("R1 addr%0d", a), 64'(r), 64'h0);
    end

    // R11 registered lag and R7 pull direction
    wr(4'd1, 32'h3);
    check("R11 pull_up before", 64'(pad_pull_up), 64'h0);
    @(negedge clk);
    check("R7 pull_up follows data", 64'(pad_pull_up), 64'h3);
    wr(4'd4, 32'h1);
    @(negedge clk);
    check("R6 gpio oe", 64'(pad_oe), 64'h1);
    check("R6 gpio out", 64'(pad_out), 64'h3);
    check("R7 no pull on output", 64'(pad_pull_en), 64'hFFFF_FFFE);
    wr(4'd8, 32'h2);
    @(negedge clk);
    check("R7 pull disable", 64'(pad_pull_en), 64'hFFFF_FFFC);
    wr(4'd2, 32'h1);
    @(negedge clk);
    check("R6 out after clear", 64'(pad_out), 64'h2);

    // R5 / R6 alternate functions
    alt_oe = 32'h10; alt_out = 32'h10;
    wr(4'd6, 32'h50);
    wr(4'd7, 32'h60);
    @(negedge clk);
    check("R5 func codes", 64'(pad_func[15:8]), 64'b00_11_10_01);
    check("R6 alt oe", 64'(pad_oe), 64'h11);
    check("R6 alt out", 64'(pad_out), 64'h12);
    check("R7 pull with alt input", 64'(pad_pull_en), 64'hFFFF_FFEC);

    // R8 sleep override
    alt_oe = '0; alt_out = '0;
    do_reset();
    wr(4'd4, 32'h300);
    wr(4'd9, 32'h200);
    @(negedge clk);
    check("R8 awake oe", 64'(pad_oe), 64'h300);
    sleep_i = 1'b1;
    @(negedge clk);
    check("R8 sleep oe", 64'(pad_oe), 64'h200);
    check("R8 sleep pull", 64'(pad_pull_en), 64'hFFFF_FDFF);
    sleep_i = 1'b0;
    @(negedge clk);
    check("R8 wake oe", 64'(pad_oe), 64'h300);
    rd(4'd9, r);
    check("R8 sleep map read", 64'(r), 64'h200);

    // R9 synchronizer latency, R10 response timing
    @(negedge clk);
    pad_in = 32'hCAFE_BABE;
    rd(4'd0, r);
    check("R9 old value", 64'(r), 64'h0);
    check("R10 rsp_valid", 64'(rsp_valid), 64'h1);
    @(negedge clk);
    check("R10 rsp_valid drop", 64'(rsp_valid), 64'h0);
    pad_in = 32'h1234_0000;
    rd(4'd0, r);
    check("R9 still previous", 64'(r), 64'hCAFE_BABE);
    rd(4'd0, r);
    check("R9 new value", 64'(r), 64'h1234_0000);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd1, r);
    check("R9 write to pad addr ignored", 64'(r), 64'h0);
    rd(4'd0, r);
    check("R9 pad read after write", 64'(r), 64'h1234_0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule